// File: doc/BRIEF.md
# Compare/Capture Timer Channel

This block is one channel of a programmable counter array. It observes a shared free-running counter supplied from outside, together with a strobe that marks the cycles on which that counter takes a new value. A 7-bit mode word selects what the channel does, and several functions can be active in the same channel.

The channel can latch the counter when an external pin rises, falls, or changes in either direction. It can raise an event flag when the counter equals a stored 16-bit value, which makes it a software timer. It can invert an output pin on that equality, which makes it a high-speed output. It can also produce an 8-bit pulse-width-modulated waveform.

The event flag is sticky until software clears it. A separate enable bit gates the flag onto the interrupt request. The stored 16-bit value is readable at all times, and software can load it directly.

Top module: `cc_channel`

## Requirements
- R1: After reset, mode_o and ccr_o are 0, flag_o and irq_o are 0, and pin_o is 1.
- R2: mode_wdata_i is loaded when mode_we_i is high and appears on mode_o on the next cycle. Bit meanings are: bit 6 compare enable, bit 5 rising-edge capture, bit 4 falling-edge capture, bit 3 match flag enable, bit 2 toggle enable, bit 1 PWM enable, bit 0 interrupt enable.
- R3: cap_pin_i passes through two synchronizer flops. Suppose bit 5 is set and the pin rises (or bit 4 is set and it falls) just before clock edge k. At edge k+2, ccr_o takes the value of cnt_i and flag_o is set. With both bits set, either transition captures. A capture takes priority over a software write to ccr in the same cycle.
- R4: A pin transition whose direction is not enabled leaves ccr_o and flag_o unchanged.
- R5: Suppose bit 6 and bit 3 are set, bit 1 is clear, cnt_adv_i is high and cnt_i equals ccr_o. Then flag_o is set on the next cycle. Without bit 2, pin_o does not change.
- R6: Under the same match condition with bit 2 set, pin_o inverts on the next cycle.
- R7: A match is evaluated only when cnt_adv_i is high. Holding cnt_i equal to ccr_o with cnt_adv_i low sets no flag and toggles nothing.
- R8: With bit 6 clear, no match flag, no toggle and no PWM output occur, and pin_o holds its value.
- R9: With bits 6 and 1 both set, pin_o is updated every cycle to (cnt_i[7:0] >= ccr_o[7:0]), one cycle late. In this mode, matches neither set the flag nor toggle the pin.
- R10: In PWM mode, on a cycle with cnt_adv_i high and cnt_i[7:0] equal to 0, ccr_o[7:0] reloads from ccr_o[15:8].
- R11: flag_o stays set until flag_clr_i is pulsed. When a set and a clear occur in the same cycle, the flag stays set.
- R12: irq_o is high exactly when flag_o is high and mode bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Shared counter value |
| cnt_adv_i | input | 1 | High on cycles where cnt_i holds a newly advanced value |
| mode_we_i | input | 1 | Mode word write strobe |
| mode_wdata_i | input | 7 | Mode word write data |
| ccr_we_i | input | 1 | Compare/capture register write strobe |
| ccr_wdata_i | input | 16 | Compare/capture register write data |
| flag_clr_i | input | 1 | Event flag clear strobe |
| cap_pin_i | input | 1 | Asynchronous capture input |
| mode_o | output | 7 | Current mode word |
| ccr_o | output | 16 | Compare/capture register |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Gated interrupt request |
| pin_o | output | 1 | Compare/PWM output pin |

## Verification
Two situations are hard to reach from the ports. The first is a match held on a counter that has stopped advancing. The second is a set and a clear of the flag landing in the same cycle.

The stimulus handles the first by freezing cnt_i on the compare value with the advance strobe low for several cycles, and then issuing a single strobe. It handles the second by driving flag_clr_i in the very cycle in which the match strobe fires.

The PWM byte reload needs the counter's low byte to wrap while the compare register holds distinct high and low bytes. The bench loads such a value and steps the counter from 0x00FF across 0x0100. A randomized phase then mixes mode changes, pin edges and writes, and checks every cycle against the behavioural model.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int MODE_W = 7;

  // bit 6 down to bit 0
  typedef struct packed {
    logic cmp_en;
    logic cap_rise;
    logic cap_fall;
    logic match_en;
    logic tog_en;
    logic pwm_en;
    logic irq_en;
  } cc_mode_t;
endpackage

// File: rtl/cc_edge_sync.sv
module cc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synced sample, sh[STAGES] the one before it
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/cc_compare.sv
module cc_compare
  import cc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PWM_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] ccr_i,
  input  cc_mode_t         mode_i,
  output logic             hit_o,
  output logic             pwm_on_o,
  output logic             pwm_lvl_o,
  output logic             reload_o
);
  logic eq;

  assign eq        = (cnt_i == ccr_i);
  assign pwm_on_o  = mode_i.cmp_en & mode_i.pwm_en;
  assign hit_o     = mode_i.cmp_en & ~mode_i.pwm_en & adv_i & eq;
  assign pwm_lvl_o = (cnt_i[PWM_W-1:0] >= ccr_i[PWM_W-1:0]);
  assign reload_o  = pwm_on_o & adv_i & (cnt_i[PWM_W-1:0] == '0);
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PWM_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cnt_adv_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              ccr_we_i,
  input  logic [CNT_W-1:0]  ccr_wdata_i,
  input  logic              flag_clr_i,
  input  logic              cap_pin_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  ccr_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              pin_o
);
  localparam int RLD_HI = 2 * PWM_W - 1;

  cc_mode_t         mode_q;
  logic [CNT_W-1:0] ccr_q;
  logic             flag_q, pin_q;
  logic             rise, fall, cap_evt;
  logic             hit, pwm_on, pwm_lvl, reload;
  logic             flag_set;

  cc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  cc_compare #(.CNT_W(CNT_W), .PWM_W(PWM_W)) u_cmp (
    .cnt_i     (cnt_i),
    .adv_i     (cnt_adv_i),
    .ccr_i     (ccr_q),
    .mode_i    (mode_q),
    .hit_o     (hit),
    .pwm_on_o  (pwm_on),
    .pwm_lvl_o (pwm_lvl),
    .reload_o  (reload)
  );

  assign cap_evt  = (rise & mode_q.cap_rise) | (fall & mode_q.cap_fall);
  assign flag_set = cap_evt | (hit & mode_q.match_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= cc_mode_t'(mode_wdata_i);
  end

  // capture > software write > PWM reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ccr_q <= '0;
    else if (cap_evt)  ccr_q <= cnt_i;
    else if (ccr_we_i) ccr_q <= ccr_wdata_i;
    else if (reload)   ccr_q[PWM_W-1:0] <= ccr_q[RLD_HI:PWM_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (flag_set)   flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pin_q <= 1'b1;
    else if (pwm_on)                  pin_q <= pwm_lvl;
    else if (hit && mode_q.tog_en)    pin_q <= ~pin_q;
  end

  assign mode_o = mode_q;
  assign ccr_o  = ccr_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & mode_q.irq_en;
  assign pin_o  = pin_q;

  // R3
  capture_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (ccr_o == $past(cnt_i)) && flag_o);

  // R11
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  // R7
  no_adv_pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_adv_i && !(mode_o[6] && mode_o[1])) |=> $stable(pin_o));

  // R8
  cmp_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[6] |=> $stable(pin_o));

  // R10
  pwm_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[6] && mode_o[1] && cnt_adv_i && cnt_i[PWM_W-1:0] == '0 && !ccr_we_i && !cap_evt)
      |=> ccr_o[PWM_W-1:0] == $past(ccr_o[RLD_HI:PWM_W]));

  // R12
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
endmodule

// File: tb/sim_cc_channel.sv
module sim_cc_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        adv = 1'b0;
  logic        mode_we = 1'b0;
  logic [6:0]  mode_wd = '0;
  logic        ccr_we = 1'b0;
  logic [15:0] ccr_wd = '0;
  logic        clr = 1'b0;
  logic        cap_pin = 1'b0;
  logic [6:0]  mode_o;
  logic [15:0] ccr_o;
  logic        flag_o, irq_o, pin_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_adv_i(adv),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wd),
    .ccr_we_i(ccr_we), .ccr_wdata_i(ccr_wd), .flag_clr_i(clr),
    .cap_pin_i(cap_pin), .mode_o(mode_o), .ccr_o(ccr_o),
    .flag_o(flag_o), .irq_o(irq_o), .pin_o(pin_o)
  );

  // behavioural reference
  int m_mode, m_ccr, m_flag, m_pin;
  int pin_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ccr = 0; m_flag = 0; m_pin = 1;
      pin_hist = '{0, 0, 0};
    end else begin
      bit rise, fall, cap, cmp, pwm, hit;
      int c, lo;
      c    = int'(cnt);
      rise = pin_hist[1] == 1 && pin_hist[2] == 0;
      fall = pin_hist[1] == 0 && pin_hist[2] == 1;
      cap  = (rise && m_mode[5]) || (fall && m_mode[4]);
      cmp  = m_mode[6];
      pwm  = cmp && m_mode[1];
      hit  = cmp && !m_mode[1] && adv && c == m_ccr;
      if (pwm) m_pin = ((c % 256) >= (m_ccr % 256)) ? 1 : 0;
      else if (hit && m_mode[2]) m_pin = 1 - m_pin;
      if (cap || (hit && m_mode[3])) m_flag = 1;
      else if (clr) m_flag = 0;
      lo = m_ccr / 256;
      if (cap) m_ccr = c;
      else if (ccr_we) m_ccr = int'(ccr_wd);
      else if (pwm && adv && (c % 256) == 0) m_ccr = (m_ccr / 256) * 256 + lo;
      if (mode_we) m_mode = int'(mode_wd);
      pin_hist.push_front(int'(cap_pin));
      void'(pin_hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(mode_o) == m_mode, "R2 mode", int'(mode_o), m_mode);
      chk(int'(ccr_o) == m_ccr, "R3 ccr", int'(ccr_o), m_ccr);
      chk(int'(flag_o) == m_flag, "R11 flag", int'(flag_o), m_flag);
      chk(int'(irq_o) == (m_flag & m_mode[0]), "R12 irq", int'(irq_o), m_flag & m_mode[0]);
      chk(int'(pin_o) == m_pin, "R6 pin", int'(pin_o), m_pin);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_mode(input logic [6:0] v);
    mode_we = 1'b1; mode_wd = v; tick(1); mode_we = 1'b0;
  endtask

  task automatic set_ccr(input logic [15:0] v);
    ccr_we = 1'b1; ccr_wd = v; tick(1); ccr_we = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      cnt = cnt + 16'd1; adv = 1'b1; tick(1);
    end
    adv = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1
    chk(mode_o == 7'h0 && ccr_o == 16'h0, "R1 regs", int'(ccr_o), 0);
    chk(flag_o == 1'b0 && irq_o == 1'b0, "R1 flag", int'(flag_o), 0);
    chk(pin_o == 1'b1, "R1 pin", int'(pin_o), 1);
    rst_n = 1'b1;
    tick(1);

    // R2
    set_mode(7'h4C);
    chk(mode_o == 7'h4C, "R2 write", int'(mode_o), 'h4C);

    // R3: rising capture, irq enabled
    set_mode(7'h21);
    cnt = 16'h1234;
    cap_pin = 1'b1; tick(4);
    chk(ccr_o == 16'h1234, "R3 rise ccr", int'(ccr_o), 'h1234);
    chk(irq_o == 1'b1, "R12 irq on", int'(irq_o), 1);
    pulse_clr();
    chk(flag_o == 1'b0, "R11 clear", int'(flag_o), 0);

    // R4: falling edge with only rising enabled
    cnt = 16'h5555;
    cap_pin = 1'b0; tick(5);
    chk(ccr_o == 16'h1234 && flag_o == 1'b0, "R4 ignored edge", int'(ccr_o), 'h1234);

    // R3: both edges
    set_mode(7'h30);
    cnt = 16'hABCD; cap_pin = 1'b1; tick(5);
    chk(ccr_o == 16'hABCD, "R3 both rise", int'(ccr_o), 'hABCD);
    chk(irq_o == 1'b0 && flag_o == 1'b1, "R12 irq gated", int'(irq_o), 0);
    cnt = 16'h0F0F; cap_pin = 1'b0; tick(5);
    chk(ccr_o == 16'h0F0F, "R3 both fall", int'(ccr_o), 'h0F0F);
    pulse_clr();

    // R5: software timer
    set_mode(7'h48);
    set_ccr(16'h0010);
    cnt = 16'h0000;
    run(32);
    tick(1);
    chk(flag_o == 1'b1 && pin_o == 1'b1, "R5 timer", int'(flag_o), 1);
    pulse_clr();

    // R7: equal but no advance
    cnt = 16'h0010; tick(5);
    chk(flag_o == 1'b0, "R7 no adv", int'(flag_o), 0);
    adv = 1'b1; tick(1); adv = 1'b0; tick(2);
    chk(flag_o == 1'b1, "R7 single adv", int'(flag_o), 1);
    pulse_clr();

    // R11: set and clear together
    cnt = 16'h0010; adv = 1'b1; clr = 1'b1; tick(1);
    adv = 1'b0; clr = 1'b0; tick(1);
    chk(flag_o == 1'b1, "R11 set wins", int'(flag_o), 1);
    pulse_clr();

    // R6: toggle
    set_mode(7'h44);
    cnt = 16'h0000;
    run(32); tick(1);
    chk(pin_o == 1'b0, "R6 toggle", int'(pin_o), 0);

    // R8: compare disabled
    set_mode(7'h0C);
    cnt = 16'h0000;
    run(32); tick(1);
    chk(pin_o == 1'b0 && flag_o == 1'b0, "R8 cmp off", int'(pin_o), 0);

    // R9: PWM level
    set_mode(7'h42);
    set_ccr(16'h4040);
    cnt = 16'h0050; tick(2);
    chk(pin_o == 1'b1, "R9 pwm high", int'(pin_o), 1);
    cnt = 16'h0030; tick(2);
    chk(pin_o == 1'b0, "R9 pwm low", int'(pin_o), 0);
    cnt = 16'h0010; adv = 1'b1; tick(1); adv = 1'b0; tick(1);
    chk(flag_o == 1'b0, "R9 no match flag", int'(flag_o), 0);

    // R10: reload across low-byte wrap
    set_ccr(16'h8040);
    cnt = 16'h00FE;
    run(3); tick(1);
    chk(ccr_o == 16'h8080, "R10 reload", int'(ccr_o), 'h8080);
    run(600);

    // randomized phase, checked every cycle by the model
    for (int r = 0; r < 3000; r++) begin
      if (r % 60 == 0) begin mode_we = 1'b1; mode_wd = 7'($urandom); end
      else mode_we = 1'b0;
      ccr_we = ($urandom % 40) == 0;
      ccr_wd = 16'($urandom % 64);
      clr = ($urandom % 10) == 0;
      if (($urandom % 7) == 0) cap_pin = ~cap_pin;
      adv = $urandom % 2;
      if (adv) cnt = (cnt + 16'd1) % 16'd64;
      tick(1);
    end
    mode_we = 1'b0; ccr_we = 1'b0; clr = 1'b0; adv = 1'b0;
    tick(4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule